// File: doc/BRIEF.md
# Two-Tier Touch Confirmation Filter

This block decides which keys of a scanned touch matrix count as pressed. A scanner sends it a burst result after each acquisition burst. The result names the key that was sampled and says whether that burst went over its threshold. The filter nests two consecutive-count filters for each key.

The inner (fast) count runs while the scanner stays on one key. Each over-threshold burst raises it, and the block asks the scanner to fire another burst on the same key straight away. When the inner count reaches the key's fast limit, the visit has passed. The outer (normal) count then advances, but at most once per full matrix scan. A key becomes active when its outer count reaches the key's normal limit. A key is therefore confirmed only after fast limit × normal limit over-threshold bursts in a row. Any below-threshold burst ends the visit, clears the outer count and drops the key's active bit.

The limits come from a flat configuration table with one 4-bit field per key for each tier. A normal limit of zero takes the key out of service.

Control is a two-state machine:
- **ST_IDLE**: no visit is in progress. The next burst result starts a visit on the key it names.
- **ST_REPEAT**: the block is inside an inner sequence on the latched key, and the repeat request is raised.

The machine has four transitions:
- **ST_IDLE → ST_REPEAT**: an over-threshold result on an enabled key whose inner count is still below its fast limit.
- **ST_REPEAT → ST_REPEAT**: another over-threshold result that is still short of the fast limit.
- **ST_REPEAT → ST_IDLE (pass)**: an over-threshold result reaches the fast limit.
- **any → ST_IDLE (fail or disabled)**: a below-threshold result, or any result on a key whose normal limit is zero.

A pass taken directly from ST_IDLE (fast limit 1) keeps the machine in ST_IDLE.

Top module: `touch_confirm`

## Requirements
- R1: While `rst_n` is low, and after it is released, `key_active` is all zeros and `repeat_req` is low. All inner and outer counts start from zero.
- R2: Each over-threshold result raises the visit's inner count by one. `repeat_req` goes high in the cycle after such a result if the new count is still below the key's fast limit, and stays high until the next result. A fast limit of 0 acts as 1.
- R3: A below-threshold result ends the visit. In the next cycle `repeat_req` is low, the key's outer count is zero and its active bit is clear.
- R4: Every visit starts with an inner count of zero. A visit that failed part way contributes nothing to the next visit.
- R5: The outer count advances by one when an inner sequence reaches its fast limit, and at most once between two `scan_start` pulses. A `scan_start` that arrives in the same cycle as a result takes effect first.
- R6: A key's active bit sets in the cycle after the result that brings its outer count to its normal limit. This takes exactly fast limit × normal limit over-threshold results, spread over normal-limit scans.
- R7: A key whose normal limit is 0 never raises `repeat_req` and never becomes active. Its counts are held at zero.
- R8: An active key stays active through later visits that pass, including extra visits within one scan.
- R9: Key k takes its fast limit from `cfg_fast[4k+3:4k]` and its normal limit from `cfg_norm[4k+3:4k]`. The result for key k updates only bit k of `key_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_start | input | 1 | One-cycle pulse at the start of each full matrix scan |
| res_valid | input | 1 | A burst result is present this cycle |
| key_idx | input | KEY_W | Key that the burst sampled (ignored while a repeat is pending) |
| over_thr | input | 1 | The burst exceeded its threshold |
| cfg_fast | input | NKEYS*CNT_W | Per-key fast (inner) limits |
| cfg_norm | input | NKEYS*CNT_W | Per-key normal (outer) limits; 0 disables the key |
| repeat_req | output | 1 | Scanner must repeat the burst on the same key |
| key_active | output | NKEYS | Confirmed-touch bitmap |

## Verification
The hardest condition to produce from the ports is a second passing visit to the same key within one scan. The scanner does not normally do this. If the once-per-scan gate were missing, such a visit would advance the outer count early. The bench sweeps every fast limit from 0 to 4 against every normal limit from 0 to 3, and in every scan it sends a second full passing visit. It checks that activation still lands on exactly the normal-limit scan. Failures part way through a sequence are also injected, to show that the next visit restarts its inner count.

// File: rtl/tc_pkg.sv
package tc_pkg;
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_REPEAT = 1'b1
    } tc_state_e;
endpackage

// File: rtl/tc_limit_sel.sv
module tc_limit_sel #(
    parameter int NKEYS = 24,
    parameter int CNT_W = 4,
    parameter int KEY_W = 5
) (
    input  logic [KEY_W-1:0]       sel,
    input  logic [NKEYS*CNT_W-1:0] table_i,
    output logic [CNT_W-1:0]       lim_o
);
    // Out-of-range index yields zero, i.e. a disabled key.
    always_comb begin
        lim_o = '0;
        for (int i = 0; i < NKEYS; i++) begin
            if (sel == KEY_W'(i)) lim_o = table_i[i*CNT_W +: CNT_W];
        end
    end
endmodule

// File: rtl/tc_outer_bank.sv
module tc_outer_bank #(
    parameter int NKEYS = 24,
    parameter int CNT_W = 4,
    parameter int KEY_W = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scan_start,
    input  logic [KEY_W-1:0]       upd_key,
    input  logic                   upd_pass,
    input  logic                   upd_fail,
    input  logic [NKEYS*CNT_W-1:0] norm_table,
    output logic [NKEYS-1:0]       active_o
);
    for (genvar k = 0; k < NKEYS; k++) begin : g_key
        logic [CNT_W-1:0] lim_k;
        logic [CNT_W-1:0] outer_q;
        logic             adv_q;
        logic             adv_now;
        logic             hit;
        logic             act_q;

        assign lim_k       = norm_table[k*CNT_W +: CNT_W];
        assign adv_now     = adv_q & ~scan_start;   // scan boundary re-arms first
        assign hit         = (upd_key == KEY_W'(k));
        assign active_o[k] = act_q;

        always_ff @(posedge clk) begin
            if (!rst_n || lim_k == '0) begin
                outer_q <= '0;
                adv_q   <= 1'b0;
                act_q   <= 1'b0;
            end else begin
                adv_q <= adv_now;
                if (hit && upd_pass && !adv_now) begin
                    adv_q <= 1'b1;
                    if (({1'b0, outer_q} + (CNT_W+1)'(1)) >= {1'b0, lim_k}) begin
                        outer_q <= lim_k;
                        act_q   <= 1'b1;
                    end else begin
                        outer_q <= outer_q + CNT_W'(1);
                    end
                end else if (hit && upd_fail) begin
                    outer_q <= '0;
                    act_q   <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/touch_confirm.sv
module touch_confirm #(
    parameter int NKEYS = 24,
    parameter int CNT_W = 4,
    localparam int KEY_W = (NKEYS > 1) ? $clog2(NKEYS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scan_start,
    input  logic                   res_valid,
    input  logic [KEY_W-1:0]       key_idx,
    input  logic                   over_thr,
    input  logic [NKEYS*CNT_W-1:0] cfg_fast,
    input  logic [NKEYS*CNT_W-1:0] cfg_norm,
    output logic                   repeat_req,
    output logic [NKEYS-1:0]       key_active
);
    import tc_pkg::*;

    tc_state_e        st_q, st_d;
    logic [KEY_W-1:0] cur_key_q, sel_key;
    logic [CNT_W-1:0] inner_q, inner_d, base;
    logic [CNT_W-1:0] fast_lim, norm_lim, fast_eff;
    logic [CNT_W:0]   inner_inc;
    logic             pass, fail;

    assign sel_key  = (st_q == ST_REPEAT) ? cur_key_q : key_idx;
    assign fast_eff = (fast_lim == '0) ? CNT_W'(1) : fast_lim;

    tc_limit_sel #(.NKEYS(NKEYS), .CNT_W(CNT_W), .KEY_W(KEY_W)) u_fast_sel (
        .sel(sel_key), .table_i(cfg_fast), .lim_o(fast_lim)
    );
    tc_limit_sel #(.NKEYS(NKEYS), .CNT_W(CNT_W), .KEY_W(KEY_W)) u_norm_sel (
        .sel(sel_key), .table_i(cfg_norm), .lim_o(norm_lim)
    );

    // Next-state and inner-count logic
    always_comb begin
        st_d    = st_q;
        inner_d = inner_q;
        pass    = 1'b0;
        fail    = 1'b0;
        unique case (st_q)
            ST_IDLE:   base = '0;        // fresh visit: inner count restarts
            ST_REPEAT: base = inner_q;
        endcase
        inner_inc = {1'b0, base} + (CNT_W+1)'(1);
        if (res_valid) begin
            if (norm_lim == '0) begin
                st_d    = ST_IDLE;
                inner_d = '0;
            end else if (!over_thr) begin
                fail    = 1'b1;
                st_d    = ST_IDLE;
                inner_d = '0;
            end else if (inner_inc >= {1'b0, fast_eff}) begin
                pass    = 1'b1;
                st_d    = ST_IDLE;
                inner_d = '0;
            end else begin
                st_d    = ST_REPEAT;
                inner_d = inner_inc[CNT_W-1:0];
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            inner_q   <= '0;
            cur_key_q <= '0;
        end else begin
            st_q    <= st_d;
            inner_q <= inner_d;
            if (res_valid) cur_key_q <= sel_key;
        end
    end

    // Outputs
    always_comb begin
        repeat_req = (st_q == ST_REPEAT);
    end

    tc_outer_bank #(.NKEYS(NKEYS), .CNT_W(CNT_W), .KEY_W(KEY_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .scan_start(scan_start),
        .upd_key(sel_key), .upd_pass(pass), .upd_fail(fail),
        .norm_table(cfg_norm), .active_o(key_active)
    );
endmodule

// File: rtl/tc_check.sv
module tc_check #(
    parameter int NKEYS = 24,
    parameter int CNT_W = 4,
    localparam int KEY_W = (NKEYS > 1) ? $clog2(NKEYS) : 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   scan_start,
    input logic                   res_valid,
    input logic [KEY_W-1:0]       key_idx,
    input logic                   over_thr,
    input logic [NKEYS*CNT_W-1:0] cfg_fast,
    input logic [NKEYS*CNT_W-1:0] cfg_norm,
    input logic                   repeat_req,
    input logic [NKEYS-1:0]       key_active
);
    logic [NKEYS-1:0] en_mask;
    logic [CNT_W-1:0] fast_of, norm_of;
    logic             idx_ok;

    always_comb begin
        for (int i = 0; i < NKEYS; i++) en_mask[i] = (cfg_norm[i*CNT_W +: CNT_W] != '0);
        idx_ok  = (int'(key_idx) < NKEYS);
        fast_of = '0;
        norm_of = '0;
        for (int i = 0; i < NKEYS; i++) begin
            if (key_idx == KEY_W'(i)) begin
                fast_of = cfg_fast[i*CNT_W +: CNT_W];
                norm_of = cfg_norm[i*CNT_W +: CNT_W];
            end
        end
    end

    p_rep_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && over_thr && !repeat_req && idx_ok && fast_of > CNT_W'(1) && norm_of != '0)
        |=> repeat_req);

    p_rep_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !over_thr) |=> !repeat_req);

    p_fail_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !over_thr && !repeat_req && idx_ok) |=> !key_active[$past(key_idx)]);

    p_rise_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(key_active & ~$past(key_active))) |-> $past(res_valid && over_thr));

    p_disabled_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((key_active & ~$past(en_mask)) == '0));

    p_no_rep_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !repeat_req && norm_of == '0) |=> !repeat_req);
endmodule

bind touch_confirm tc_check #(.NKEYS(NKEYS), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/touch_confirm_tb.sv
`timescale 1ns/1ps
module touch_confirm_tb;
    localparam int NK = 4;
    localparam int CW = 4;
    localparam int KW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scan_start = 1'b0;
    logic          res_valid = 1'b0;
    logic [KW-1:0] key_idx = '0;
    logic          over_thr = 1'b0;
    logic [NK*CW-1:0] cfg_fast = '0;
    logic [NK*CW-1:0] cfg_norm = '0;
    logic          repeat_req;
    logic [NK-1:0] key_active;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    touch_confirm #(.NKEYS(NK), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .scan_start(scan_start), .res_valid(res_valid),
        .key_idx(key_idx), .over_thr(over_thr), .cfg_fast(cfg_fast), .cfg_norm(cfg_norm),
        .repeat_req(repeat_req), .key_active(key_active)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one result; returns at the negedge after the consuming edge.
    task automatic burst(input int k, input bit ov);
        @(negedge clk);
        res_valid = 1'b1; key_idx = KW'(k); over_thr = ov;
        @(negedge clk);
        res_valid = 1'b0; over_thr = 1'b0;
    endtask

    task automatic scan_begin();
        @(negedge clk);
        scan_start = 1'b1;
        @(negedge clk);
        scan_start = 1'b0;
    endtask

    task automatic set_all(input int f, input int n);
        for (int j = 0; j < NK; j++) begin
            cfg_fast[j*CW +: CW] = CW'(f);
            cfg_norm[j*CW +: CW] = CW'(n);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 active in reset", int'(key_active), 0);
        chk("R1 repeat in reset", int'(repeat_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 active after reset", int'(key_active), 0);

        // Sweep of fast limit 0..4 against normal limit 0..3
        for (int f = 0; f <= 4; f++) begin
            for (int n = 0; n <= 3; n++) begin
                int fe;
                int k;
                fe = (f == 0) ? 1 : f;
                k = (f + n) % NK;
                set_all(f, n);
                for (int j = 0; j < NK; j++) burst(j, 1'b0);
                chk("R3 cleared before run", int'(key_active), 0);
                for (int s = 1; s <= n + 1; s++) begin
                    int exp_act;
                    scan_begin();
                    exp_act = (n != 0 && s >= n) ? (1 << k) : 0;
                    for (int v = 0; v < 2; v++) begin
                        for (int i = 0; i < fe; i++) begin
                            burst(k, 1'b1);
                            chk((n == 0) ? "R7 no repeat when disabled" : "R2 repeat request",
                                int'(repeat_req), (n != 0 && i + 1 < fe) ? 1 : 0);
                        end
                        // v=1 is a second visit in the same scan: R5 gate, R8 hold
                        chk((v == 0) ? "R6 activation after product" : "R5 once per scan / R8 hold",
                            int'(key_active), exp_act);
                    end
                end
                burst(k, 1'b0);
                chk("R3 fail clears active", int'(key_active), 0);
                chk("R3 fail drops repeat", int'(repeat_req), 0);
                if (fe >= 2 && n != 0) begin
                    burst(k, 1'b1);
                    chk("R2 repeat mid sequence", int'(repeat_req), 1);
                    burst(k, 1'b0);
                    chk("R3 mid-sequence fail drops repeat", int'(repeat_req), 0);
                    for (int i = 0; i < fe; i++) begin
                        burst(k, 1'b1);
                        chk("R4 inner restarts per visit", int'(repeat_req), (i + 1 < fe) ? 1 : 0);
                    end
                end
            end
        end

        // R9: per-key limit routing and bit isolation
        set_all(1, 1);
        cfg_fast[2*CW +: CW] = 4'd3;
        cfg_norm[3*CW +: CW] = 4'd0;
        for (int j = 0; j < NK; j++) burst(j, 1'b0);
        scan_begin();
        burst(0, 1'b1);
        chk("R9 key0 fast limit 1", int'(repeat_req), 0);
        chk("R9 only key0 active", int'(key_active), 1);
        burst(2, 1'b1);
        chk("R9 key2 uses its own fast limit", int'(repeat_req), 1);
        burst(2, 1'b1);
        burst(2, 1'b1);
        chk("R9 key2 active after 3", int'(key_active), 5);
        burst(3, 1'b1);
        chk("R7 disabled key3 inactive", int'(key_active), 5);

        // R5: scan_start coinciding with a result counts first
        set_all(1, 2);
        for (int j = 0; j < NK; j++) burst(j, 1'b0);
        scan_begin();
        burst(1, 1'b1);
        chk("R5 one advance", int'(key_active), 0);
        @(negedge clk);
        scan_start = 1'b1; res_valid = 1'b1; key_idx = 2'd1; over_thr = 1'b1;
        @(negedge clk);
        scan_start = 1'b0; res_valid = 1'b0; over_thr = 1'b0;
        chk("R5 same-cycle scan_start re-arms", int'(key_active), 2);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule